// File: doc/BRIEF.md
# Mixed-Grained Parity Fault Detector

This block checks the words leaving each stage of a 32-bit cipher datapath against faults caused by timing disturbances such as clock glitches. Each stage has a stored even-parity vector that was computed when the word was correct. The block recomputes the parity of the word as it arrives and compares it against the stored vector. A word that fails the comparison raises an error flag, and that flag also latches a sticky alarm.

The parity granularity is chosen per stage from a 12-entry configuration table, which is a parameter. A critical stage splits the word into 8-bit or 16-bit subwords, each with its own parity bit. A non-critical stage covers the whole word with one parity bit. All stages share one checker. The datapath presents the word, its stored parity, the stage index and a valid strobe. Results appear one cycle later.

Top module: `mgp_fault_detector`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `chk_valid`, `chk_err`, `chk_groups` and `alarm` are all 0.
- R2: Granularity code 2 means 8-bit groups. Group i covers `word[8i+7:8i]` and is checked against `par[i]` for i = 0..3. `chk_groups[i]` is 1 exactly when the XOR of that byte differs from `par[i]`.
- R3: Granularity code 1 means 16-bit groups. Group j covers `word[16j+15:16j]` and is checked against `par[j]` for j = 0..1. `par[3:2]` has no effect, and `chk_groups[3:2]` stays 0.
- R4: Granularity code 0 means one group: the XOR of all 32 bits is compared with `par[0]`. `par[3:1]` has no effect, and `chk_groups[3:1]` stays 0.
- R5: The default table assigns code 2 to stages 0 and 11, code 1 to stages 1 and 10, and code 0 to stages 2 to 9. Entry s sits in bits `[2s+1:2s]` of `STAGE_GRAN`.
- R6: A stage index of 12 or above, and a table code of 3, are both checked as whole-word (code 0).
- R7: A word presented with `in_valid` high at a clock edge gives its result after that edge: `chk_valid` is 1 and `chk_groups` shows the result. After an edge with `in_valid` low, `chk_valid` and `chk_groups` are 0.
- R8: `chk_err` is the OR of `chk_groups`.
- R9: `alarm` becomes 1 at the same edge that `chk_err` becomes 1. It then stays 1 until a clear.
- R10: `alarm_clr` high at an edge clears `alarm`, unless an error is being registered at that same edge. In that case `alarm` stays 1.
- R11: An even number of flipped bits inside one group leaves that group's flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Word, parity and stage are valid this cycle |
| in_stage | input | 4 | Index of the cipher stage that produced the word |
| in_word | input | 32 | Data word to check |
| in_par | input | 4 | Stored even-parity bits, group 0 in bit 0 |
| alarm_clr | input | 1 | Synchronous clear of the sticky alarm |
| chk_valid | output | 1 | A check result is present this cycle |
| chk_err | output | 1 | At least one group mismatched |
| chk_groups | output | 4 | Per-group mismatch flags |
| alarm | output | 1 | Sticky fault alarm |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle link between `in_valid` and `chk_valid`;
- that no group flag is raised without a valid check;
- that upper group flags stay clear for stages outside the table;
- the stickiness of `alarm`, and that it only rises together with an error.

Only the bench scenarios can show the parity behaviour itself. These scenarios cover:
- which byte or half-word a flipped bit is blamed on under each stage's granularity;
- that unused stored parity bits are ignored;
- that double flips inside one group escape detection;
- the priority of a new error over a simultaneous alarm clear.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
  typedef enum logic [1:0] {
    GRAN_WORD = 2'd0,
    GRAN_HALF = 2'd1,
    GRAN_BYTE = 2'd2,
    GRAN_RSVD = 2'd3
  } gran_e;
endpackage

// File: rtl/mgp_gran_lut.sv
module mgp_gran_lut
  import mgp_pkg::*;
#(
  parameter int NUM_STAGES = 12,
  parameter int STAGE_W    = 4,
  parameter logic [2*NUM_STAGES-1:0] STAGE_GRAN = '0
) (
  input  logic [STAGE_W-1:0] stage,
  output gran_e              gran
);
  logic [1:0] raw;

  always_comb begin
    raw = 2'd0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (stage == STAGE_W'(s)) raw = STAGE_GRAN[2*s +: 2];
    end
    // reserved code falls back to whole-word coverage
    gran = (raw == 2'd3) ? GRAN_WORD : gran_e'(raw);
  end
endmodule

// File: rtl/mgp_lane_parity.sv
module mgp_lane_parity #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [LANES-1:0]  lane_par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/mgp_group_cmp.sv
module mgp_group_cmp
  import mgp_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  gran_e             gran,
  input  logic [GROUPS-1:0] lane_par,
  input  logic [GROUPS-1:0] stored,
  output logic [GROUPS-1:0] mism
);
  localparam int HALVES = GROUPS / 2;

  always_comb begin
    mism = '0;
    unique case (gran)
      GRAN_BYTE: mism = lane_par ^ stored;
      GRAN_HALF: begin
        for (int j = 0; j < HALVES; j++) begin
          mism[j] = lane_par[2*j] ^ lane_par[2*j+1] ^ stored[j];
        end
      end
      default: mism[0] = (^lane_par) ^ stored[0];
    endcase
  end
endmodule

// File: rtl/mgp_fault_detector.sv
module mgp_fault_detector
  import mgp_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LANE_W     = 8,
  parameter int NUM_STAGES = 12,
  parameter logic [2*NUM_STAGES-1:0] STAGE_GRAN = 24'h900006,
  localparam int GROUPS  = WORD_W / LANE_W,
  localparam int STAGE_W = $clog2(NUM_STAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [STAGE_W-1:0] in_stage,
  input  logic [WORD_W-1:0] in_word,
  input  logic [GROUPS-1:0] in_par,
  input  logic              alarm_clr,
  output logic              chk_valid,
  output logic              chk_err,
  output logic [GROUPS-1:0] chk_groups,
  output logic              alarm
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  gran_e             gran;
  logic [GROUPS-1:0] lane_par;
  logic [GROUPS-1:0] mism;

  mgp_gran_lut #(
    .NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W), .STAGE_GRAN(STAGE_GRAN)
  ) u_lut (
    .stage(in_stage), .gran(gran)
  );

  mgp_lane_parity #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_par (
    .word(in_word), .lane_par(lane_par)
  );

  mgp_group_cmp #(.GROUPS(GROUPS)) u_cmp (
    .gran(gran), .lane_par(lane_par), .stored(in_par), .mism(mism)
  );

  logic              valid_d;
  logic [GROUPS-1:0] groups_d;
  logic              err_d;
  logic              alarm_d;
  logic              alarm_en;

  always_comb begin
    valid_d  = in_valid;
    groups_d = in_valid ? mism : '0;
    err_d    = |groups_d;
    alarm_en = err_d | alarm_clr;
    alarm_d  = err_d;          // a new error wins over a clear
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      chk_valid  <= 1'b0;
      chk_groups <= '0;
      chk_err    <= 1'b0;
    end else begin
      chk_valid  <= valid_d;
      chk_groups <= groups_d;
      chk_err    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   alarm <= 1'b0;
    else if (alarm_en) alarm <= alarm_d;
  end
endmodule

// File: rtl/mgp_fault_detector_chk.sv
module mgp_fault_detector_chk #(
  parameter int GROUPS     = 4,
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [STAGE_W-1:0] in_stage,
  input logic               alarm_clr,
  input logic               chk_valid,
  input logic               chk_err,
  input logic [GROUPS-1:0]  chk_groups,
  input logic               alarm
);
  // R7: result strobe follows the input strobe by one edge
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> chk_valid);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!chk_valid && chk_groups == '0));
  // R8: no error reported without a valid result
  p_err_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_valid);
  // R6: out-of-table stage leaves upper groups clear
  p_oor_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_stage >= STAGE_W'(NUM_STAGES)) |=> (chk_groups[GROUPS-1:1] == '0));
  // R9: alarm is set together with the error and stays set
  p_alarm_with_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> alarm);
  p_alarm_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> chk_err);
  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);
  // R10: a clear without a new error drops the alarm
  p_alarm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> (!chk_err && $past(alarm_clr)));
endmodule

bind mgp_fault_detector mgp_fault_detector_chk #(
  .GROUPS(GROUPS), .STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stage(in_stage),
  .alarm_clr(alarm_clr), .chk_valid(chk_valid), .chk_err(chk_err),
  .chk_groups(chk_groups), .alarm(alarm)
);

// File: tb/mgp_fault_detector_test.sv
module mgp_fault_detector_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_stage;
  logic [31:0] in_word;
  logic [3:0]  in_par;
  logic        alarm_clr;
  logic        chk_valid;
  logic        chk_err;
  logic [3:0]  chk_groups;
  logic        alarm;

  int tests = 0;
  int fails = 0;
  logic exp_alarm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgp_fault_detector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stage(in_stage),
    .in_word(in_word), .in_par(in_par), .alarm_clr(alarm_clr),
    .chk_valid(chk_valid), .chk_err(chk_err), .chk_groups(chk_groups),
    .alarm(alarm)
  );

  // R5 table as the bench understands it; R6 fallback
  function automatic int gran_of(input logic [3:0] st);
    case (st)
      4'd0, 4'd11: return 2;
      4'd1, 4'd10: return 1;
      default:     return 0;
    endcase
  endfunction

  function automatic logic [3:0] good_par(input logic [3:0] st, input logic [31:0] w);
    logic [3:0] p = '0;
    case (gran_of(st))
      2: for (int i = 0; i < 4; i++) p[i] = ^w[8*i +: 8];
      1: for (int j = 0; j < 2; j++) p[j] = ^w[16*j +: 16];
      default: p[0] = ^w;
    endcase
    return p;
  endfunction

  function automatic logic [3:0] exp_groups(input logic [3:0] st, input logic [31:0] w,
                                            input logic [3:0] p);
    logic [3:0] g = '0;
    case (gran_of(st))
      2: for (int i = 0; i < 4; i++) g[i] = (^w[8*i +: 8]) != p[i];
      1: for (int j = 0; j < 2; j++) g[j] = (^w[16*j +: 16]) != p[j];
      default: g[0] = (^w) != p[0];
    endcase
    return g;
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic step(input string tag, input logic v, input logic [3:0] st,
                      input logic [31:0] w, input logic [3:0] p, input logic clr);
    logic [3:0] eg;
    in_valid = v; in_stage = st; in_word = w; in_par = p; alarm_clr = clr;
    eg = v ? exp_groups(st, w, p) : 4'd0;
    if (|eg) exp_alarm = 1'b1;
    else if (clr) exp_alarm = 1'b0;
    @(negedge clk);
    tests++;
    if (chk_valid !== v || chk_groups !== eg || chk_err !== (|eg) || alarm !== exp_alarm) begin
      fails++;
      $display("FAIL %s: valid=%b groups=%b err=%b alarm=%b expected valid=%b groups=%b err=%b alarm=%b",
               tag, chk_valid, chk_groups, chk_err, alarm, v, eg, |eg, exp_alarm);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd48611);
    rst_n = 1'b0; in_valid = 1'b0; in_stage = '0; in_word = '0; in_par = '0; alarm_clr = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if (chk_valid !== 1'b0 || chk_err !== 1'b0 || chk_groups !== 4'd0 || alarm !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%b err=%b groups=%b alarm=%b expected all 0",
               chk_valid, chk_err, chk_groups, alarm);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 idle cycle
    step("R7 idle", 1'b0, 4'd0, 32'hFFFF_0001, 4'hF, 1'b0);
    // R2 stage 0 byte groups: clean, then one flip in byte 2
    step("R2 clean", 1'b1, 4'd0, 32'h1234_5678, good_par(4'd0, 32'h1234_5678), 1'b0);
    step("R2 byte2 flip", 1'b1, 4'd0, 32'h1234_5678 ^ 32'h0004_0000,
         good_par(4'd0, 32'h1234_5678), 1'b0);
    // R10 clear with no new error
    step("R10 clear", 1'b1, 4'd11, 32'hA5A5_0F0F, good_par(4'd11, 32'hA5A5_0F0F), 1'b1);
    // R11 double flip in one byte escapes
    step("R11 double flip", 1'b1, 4'd11, 32'hA5A5_0F0F ^ 32'h0000_0300,
         good_par(4'd11, 32'hA5A5_0F0F), 1'b0);
    // R3 stage 1 halves: upper stored bits ignored, flip upper half
    step("R3 par ignored", 1'b1, 4'd1, 32'hDEAD_BEEF, good_par(4'd1, 32'hDEAD_BEEF) ^ 4'hC, 1'b0);
    step("R3 high half flip", 1'b1, 4'd10, 32'hDEAD_BEEF ^ 32'h8000_0000,
         good_par(4'd10, 32'hDEAD_BEEF), 1'b0);
    // R10 clear coinciding with an error: error wins
    step("R10 err beats clear", 1'b1, 4'd5, 32'h0000_0001, 4'h0, 1'b1);
    step("R9 sticky", 1'b0, 4'd5, 32'h0, 4'h0, 1'b0);
    step("R10 clear again", 1'b0, 4'd5, 32'h0, 4'h0, 1'b1);
    // R4 whole word: flips in two bytes cancel, upper stored bits ignored
    step("R4 par ignored", 1'b1, 4'd4, 32'h0101_0000, 4'hE, 1'b0);
    step("R4 single flip", 1'b1, 4'd9, 32'h0000_0080, 4'h0, 1'b0);
    // R6 out-of-range stage checked as whole word
    step("R6 oor", 1'b1, 4'd13, 32'h0100_0001, 4'hF, 1'b1);
    step("R6 oor flip", 1'b1, 4'd15, 32'h0000_0100, 4'h2, 1'b0);

    // constrained random traffic (R2..R11)
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  st;
      logic [31:0] w;
      logic [3:0]  p;
      int          mode;
      st = 4'($urandom % 16);
      w  = $urandom;
      p  = good_par(st, w);
      mode = $urandom % 4;
      if (mode == 1) w = w ^ (32'd1 << ($urandom % 32));
      if (mode == 2) p = p ^ (4'd1 << ($urandom % 4));
      if (mode == 3) w = w ^ (32'd1 << ($urandom % 32)) ^ (32'd1 << ($urandom % 32));
      step("R8 random", ($urandom % 8) != 0, st, w, p, ($urandom % 16) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule